// File: doc/BRIEF.md
# In-Order Commit Buffer with Deferred Faults

This block keeps micro-ops in program order while they run out of order. A new micro-op is written at the tail slot and gets back a slot index extended by a wrap bit. An execution unit later reports completion with that index and may raise a fault flag at the same time. Retirement takes micro-ops from the head, oldest first. Up to two micro-ops retire in one cycle, and only while every one of them has completed without a fault.

A fault does not act when it is reported. It is stored with its entry and waits there. Only when that entry becomes the oldest one does the block drop it together with everything younger. The next cycle then carries a one-cycle flush pulse, which also gives the tag of the faulting micro-op. A fault on a wrong-path or younger entry therefore costs nothing, because an older fault or flush removes it first.

An interrupt request removes all in-flight work at once and leaves the retired state as it was. It does not wait for outstanding completions. Completion reports that arrive for entries already removed are dropped by comparing the index and wrap bit with the live window.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty, `alloc_ready` is 1, `retire_valid` is 0 and `flush` is 0.
- R2: Allocation happens when `alloc_valid` and `alloc_ready` are both high. The `alloc_idx` returned is the tail pointer: bits [3:0] give the slot and bit 4 gives the wrap bit. The pointer advances by one for each allocation and counts modulo 32.
- R3: Sixteen entries hold `alloc_ready` low until one entry leaves.
- R4: Retirement follows program order. `retire_valid` bit 0 is the oldest entry and bit 1 is the next one. A slot retires only when it is executed, has no fault, and every older slot in the same cycle is also retiring. `retire_tag[7:0]` belongs to slot 0 and `retire_tag[15:8]` to slot 1.
- R5: A completion report at a clock edge sets the executed mark of the entry. That entry can retire, combinationally, in the cycle that follows.
- R6: When the head entry has completed with its fault flag set, it does not retire. In that cycle allocation is blocked and every entry is discarded. In the next cycle `flush` is 1, `flush_cause` is 0 and `flush_tag` holds the tag of the faulting entry.
- R7: When several entries carry faults, only the oldest one takes effect. An entry with a fault behind an unexecuted older entry waits.
- R8: An `irq` high during a cycle has three effects in that cycle: no entry retires, allocation is blocked, and every entry is discarded. In the next cycle `flush` is 1 and `flush_cause` is 1.
- R9: `flush` stays high for exactly one cycle per event, and `alloc_ready` is 0 during that cycle.
- R10: A completion report is ignored when the distance from the head to its index, with the wrap bit included and taken modulo 32, is not below the occupancy. It is also ignored in a cycle where a flush is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request to append a micro-op |
| alloc_tag | input | 8 | Tag carried by the new micro-op |
| alloc_ready | output | 1 | Allocation accepted this cycle |
| alloc_idx | output | 5 | Slot index plus wrap bit given to the new entry |
| cmpl_valid | input | 1 | Completion report valid |
| cmpl_idx | input | 5 | Index plus wrap bit of the completed entry |
| cmpl_fault | input | 1 | Completed micro-op has a fault |
| irq | input | 1 | Interrupt request: discard all in-flight work |
| retire_valid | output | 2 | Retiring slots, bit 0 oldest |
| retire_tag | output | 16 | Tags of the retiring slots |
| flush | output | 1 | One-cycle discard pulse |
| flush_cause | output | 1 | 0 fault, 1 interrupt |
| flush_tag | output | 8 | Tag of the faulting entry (0 for interrupt) |

## Verification
The bench runs directed cases first and then random traffic.

- **Out-of-order completion.** The younger entry finishes before the older one. A retire chain that ignored contiguity would retire the younger entry first.
- **Two faults.** A younger fault is reported before an older one. A design that acted at report time, or picked the wrong entry, would give the younger tag in `flush_tag`.
- **Stale completions.** Reports are sent with a flipped wrap bit and with indices past the tail after a flush. A check that compared only the slot bits would mark new entries as executed, and they would retire too early.
- **Interrupt and flush timing.** An interrupt arrives while completions are still pending. A design that let retirement or allocation slip through in the event or pulse cycle, or held the pulse longer, would show a mismatch at the ports.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic {
    CAUSE_FAULT = 1'b0,
    CAUSE_IRQ   = 1'b1
  } flush_cause_e;

  // Distance from ring pointer b up to ring pointer a, modulo 2**pw.
  function automatic int unsigned ring_gap(int unsigned a, int unsigned b, int unsigned pw);
    int unsigned mask;
    mask = (32'd1 << pw) - 32'd1;
    return (a - b) & mask;
  endfunction

  // An index is live when it lies inside [head, head+occ).
  function automatic logic idx_live(int unsigned idx, int unsigned head,
                                    int unsigned occ, int unsigned pw);
    return ring_gap(idx, head, pw) < occ;
  endfunction

endpackage

// File: rtl/rob_entry_bank.sv
module rob_entry_bank #(
  parameter int DEPTH = 16,
  parameter int TAG_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [PTR_W-1:0]       wr_slot,
  input  logic [TAG_W-1:0]       wr_tag,
  input  logic                   done_en,
  input  logic [PTR_W-1:0]       done_slot,
  input  logic                   done_fault,
  output logic [DEPTH-1:0]       exec_o,
  output logic [DEPTH-1:0]       fault_o,
  output logic [DEPTH*TAG_W-1:0] tag_o
);

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic             ex_q, ft_q;
    logic [TAG_W-1:0] tg_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ex_q <= 1'b0;
        ft_q <= 1'b0;
        tg_q <= '0;
      end else if (wr_en && wr_slot == PTR_W'(e)) begin
        ex_q <= 1'b0;
        ft_q <= 1'b0;
        tg_q <= wr_tag;
      end else if (done_en && done_slot == PTR_W'(e)) begin
        ex_q <= 1'b1;
        ft_q <= done_fault;
      end
    end
    assign exec_o[e]                 = ex_q;
    assign fault_o[e]                = ft_q;
    assign tag_o[e*TAG_W +: TAG_W]   = tg_q;
  end

endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel #(
  parameter int DEPTH = 16,
  parameter int TAG_W = 8,
  parameter int RET_W = 2,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int PW    = PTR_W + 1
) (
  input  logic [PW-1:0]          head,
  input  logic [PW-1:0]          occ,
  input  logic [DEPTH-1:0]       exec_i,
  input  logic [DEPTH-1:0]       fault_i,
  input  logic [DEPTH*TAG_W-1:0] tag_i,
  output logic [RET_W-1:0]       ok,
  output logic [RET_W*TAG_W-1:0] ok_tag,
  output logic                   fault_hit,
  output logic [TAG_W-1:0]       fault_tag
);

  logic [TAG_W-1:0] tag_arr [DEPTH];
  for (genvar e = 0; e < DEPTH; e++) begin : g_unpack
    assign tag_arr[e] = tag_i[e*TAG_W +: TAG_W];
  end

  logic [PTR_W-1:0] h0;
  assign h0        = head[PTR_W-1:0];
  assign fault_hit = (occ != '0) && exec_i[h0] && fault_i[h0];
  assign fault_tag = tag_arr[h0];

  for (genvar k = 0; k < RET_W; k++) begin : g_slot
    logic [PTR_W-1:0] slot;
    logic             present, clean;
    assign slot    = h0 + PTR_W'(k);
    assign present = occ > PW'(k);
    assign clean   = present && exec_i[slot] && !fault_i[slot];
    if (k == 0) begin : g_first
      assign ok[k] = clean;
    end else begin : g_next
      assign ok[k] = clean && ok[k-1];
    end
    assign ok_tag[k*TAG_W +: TAG_W] = tag_arr[slot];
  end

endmodule

// File: rtl/rob_core.sv
module rob_core #(
  parameter int DEPTH = 16,
  parameter int TAG_W = 8,
  parameter int RET_W = 2,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int PW    = PTR_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc_valid,
  input  logic [TAG_W-1:0]       alloc_tag,
  output logic                   alloc_ready,
  output logic [PW-1:0]          alloc_idx,
  input  logic                   cmpl_valid,
  input  logic [PW-1:0]          cmpl_idx,
  input  logic                   cmpl_fault,
  input  logic                   irq,
  output logic [RET_W-1:0]       retire_valid,
  output logic [RET_W*TAG_W-1:0] retire_tag,
  output logic                   flush,
  output logic                   flush_cause,
  output logic [TAG_W-1:0]       flush_tag
);
  import rob_pkg::*;

  logic [PW-1:0]          head_q, tail_q;
  logic                   flush_q;
  flush_cause_e           cause_q;
  logic [TAG_W-1:0]       ftag_q;

  logic [PW-1:0]          occupancy;
  logic [DEPTH-1:0]       exec_vec, fault_vec;
  logic [DEPTH*TAG_W-1:0] tag_vec;
  logic [RET_W-1:0]       sel_ok;
  logic                   fault_hit, fault_take, discard_all;
  logic [TAG_W-1:0]       fault_tag;
  logic                   alloc_fire, cmpl_live, cmpl_take;
  logic [PW-1:0]          n_ret;

  assign occupancy   = tail_q - head_q;
  assign fault_take  = fault_hit && !irq;
  assign discard_all = irq || fault_take;

  assign alloc_ready = (occupancy != PW'(DEPTH)) && !flush_q && !discard_all;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_idx   = tail_q;

  assign cmpl_live = idx_live(32'(cmpl_idx), 32'(head_q), 32'(occupancy), PW);
  assign cmpl_take = cmpl_valid && cmpl_live && !discard_all;

  rob_entry_bank #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (alloc_fire),
    .wr_slot   (tail_q[PTR_W-1:0]),
    .wr_tag    (alloc_tag),
    .done_en   (cmpl_take),
    .done_slot (cmpl_idx[PTR_W-1:0]),
    .done_fault(cmpl_fault),
    .exec_o    (exec_vec),
    .fault_o   (fault_vec),
    .tag_o     (tag_vec)
  );

  rob_retire_sel #(.DEPTH(DEPTH), .TAG_W(TAG_W), .RET_W(RET_W)) u_sel (
    .head     (head_q),
    .occ      (occupancy),
    .exec_i   (exec_vec),
    .fault_i  (fault_vec),
    .tag_i    (tag_vec),
    .ok       (sel_ok),
    .ok_tag   (retire_tag),
    .fault_hit(fault_hit),
    .fault_tag(fault_tag)
  );

  assign retire_valid = irq ? '0 : sel_ok;
  assign n_ret        = PW'($countones(retire_valid));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      flush_q <= 1'b0;
      cause_q <= CAUSE_FAULT;
      ftag_q  <= '0;
    end else begin
      flush_q <= discard_all;
      if (discard_all) begin
        cause_q <= irq ? CAUSE_IRQ : CAUSE_FAULT;
        ftag_q  <= irq ? '0 : fault_tag;
        tail_q  <= head_q;
      end else begin
        head_q <= head_q + n_ret;
        if (alloc_fire) tail_q <= tail_q + PW'(1);
      end
    end
  end

  assign flush       = flush_q;
  assign flush_cause = cause_q;
  assign flush_tag   = ftag_q;

endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
  parameter int DEPTH = 16,
  parameter int RET_W = 2,
  localparam int PW = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_ready,
  input logic             irq,
  input logic [RET_W-1:0] retire_valid,
  input logic             flush,
  input logic             flush_cause,
  input logic [PW-1:0]    occupancy,
  input logic             fault_take
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= PW'(DEPTH)); // R3
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy == PW'(DEPTH) |-> !alloc_ready); // R3
  AST_RETIRE_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid & (retire_valid + RET_W'(1))) == '0); // R4
  AST_FAULT_NO_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_take |-> retire_valid == '0); // R6
  AST_FAULT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    fault_take |=> flush && !flush_cause); // R6
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> occupancy == '0); // R6
  AST_IRQ_NO_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> retire_valid == '0); // R8
  AST_IRQ_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> flush && flush_cause); // R8
  AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !alloc_ready); // R9
  AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    flush && !irq |=> !flush); // R9

endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH), .RET_W(RET_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc_ready (alloc_ready),
  .irq         (irq),
  .retire_valid(retire_valid),
  .flush       (flush),
  .flush_cause (flush_cause),
  .occupancy   (occupancy),
  .fault_take  (fault_take)
);

// File: tb/sim_rob_core.sv
module sim_rob_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic [7:0]  alloc_tag = '0;
  logic        alloc_ready;
  logic [4:0]  alloc_idx;
  logic        cmpl_valid = 1'b0;
  logic [4:0]  cmpl_idx = '0;
  logic        cmpl_fault = 1'b0;
  logic        irq = 1'b0;
  logic [1:0]  retire_valid;
  logic [15:0] retire_tag;
  logic        flush, flush_cause;
  logic [7:0]  flush_tag;

  always #4 clk = ~clk;

  rob_core u0 (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_tag(alloc_tag),
    .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx), .cmpl_fault(cmpl_fault),
    .irq(irq),
    .retire_valid(retire_valid), .retire_tag(retire_tag),
    .flush(flush), .flush_cause(flush_cause), .flush_tag(flush_tag)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // bench model
  logic [7:0] q_tag[$];
  bit         q_ex[$];
  bit         q_ft[$];
  int         m_head = 0;
  int         m_tail = 0;
  bit         m_flush = 0;
  bit         m_cause = 0;
  logic [7:0] m_ftag = '0;
  logic [7:0] next_tag = 8'd0;

  task automatic check(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  function automatic int gap(int a, int b);
    return (a - b) & 31;
  endfunction

  task automatic step(bit av, logic [7:0] at, bit cv, logic [4:0] ci, bit cf, bit ir);
    bit         fault_now, exp_ready;
    logic [1:0] exp_rv;
    int         nret, sz;
    alloc_valid = av; alloc_tag = at;
    cmpl_valid = cv; cmpl_idx = ci; cmpl_fault = cf; irq = ir;
    #1;
    sz = q_tag.size();
    fault_now = sz > 0 && q_ex[0] && q_ft[0] && !ir;
    exp_rv = 2'b00;
    if (!ir) begin
      for (int k = 0; k < 2; k++)
        if (k < sz && q_ex[k] && !q_ft[k] && (k == 0 || exp_rv[0])) exp_rv[k] = 1'b1;
    end
    exp_ready = sz < 16 && !m_flush && !ir && !fault_now;
    check(retire_valid == exp_rv, "R4 retire_valid", retire_valid, exp_rv);
    for (int k = 0; k < 2; k++)
      if (exp_rv[k])
        check(retire_tag[k*8 +: 8] == q_tag[k], "R4 retire order", retire_tag[k*8 +: 8], q_tag[k]);
    check(alloc_ready == exp_ready, "R3 alloc_ready", alloc_ready, exp_ready);
    if (exp_ready) check(alloc_idx == 5'(m_tail), "R2 alloc_idx", alloc_idx, m_tail);
    check(flush == m_flush, "R9 flush", flush, m_flush);
    if (m_flush) begin
      check(flush_cause == m_cause, "R8 flush_cause", flush_cause, m_cause);
      if (!m_cause) check(flush_tag == m_ftag, "R6 flush_tag", flush_tag, m_ftag);
    end
    nret = (exp_rv == 2'b11) ? 2 : (exp_rv == 2'b01 ? 1 : 0);
    if (ir || fault_now) begin
      m_ftag = fault_now ? q_tag[0] : 8'd0;
      m_cause = ir;
      m_flush = 1;
      q_tag.delete(); q_ex.delete(); q_ft.delete();
      m_tail = m_head;
    end else begin
      m_flush = 0;
      if (cv && gap(int'(ci), m_head) < sz) begin
        q_ex[gap(int'(ci), m_head)] = 1'b1;
        q_ft[gap(int'(ci), m_head)] = cf;
      end
      for (int k = 0; k < nret; k++) begin
        void'(q_tag.pop_front()); void'(q_ex.pop_front()); void'(q_ft.pop_front());
      end
      m_head = (m_head + nret) & 31;
      if (av && exp_ready) begin
        q_tag.push_back(at); q_ex.push_back(1'b0); q_ft.push_back(1'b0);
        m_tail = (m_tail + 1) & 31;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    alloc_valid = 0; cmpl_valid = 0; cmpl_fault = 0; irq = 0;
    #1;
  endtask

  task automatic alloc_one();
    step(1'b1, next_tag, 1'b0, 5'd0, 1'b0, 1'b0);
    next_tag = next_tag + 8'd1;
  endtask

  task automatic cmpl(logic [4:0] ci, bit cf);
    step(1'b0, 8'd0, 1'b1, ci, cf, 1'b0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    // R1 reset state
    check(alloc_ready == 1'b1, "R1 alloc_ready", alloc_ready, 1);
    check(retire_valid == 2'b00, "R1 retire_valid", retire_valid, 0);
    check(flush == 1'b0, "R1 flush", flush, 0);

    // R3 fill to sixteen
    for (int i = 0; i < 16; i++) alloc_one();
    idle();
    check(alloc_ready == 1'b0, "R3 full", alloc_ready, 0);
    step(1'b1, 8'hEE, 1'b0, 5'd0, 1'b0, 1'b0);

    // R4/R5 younger finishes first, then older: both retire together
    cmpl(5'd1, 1'b0);
    idle();
    check(retire_valid == 2'b00, "R4 younger waits", retire_valid, 0);
    cmpl(5'd0, 1'b0);
    idle();
    check(retire_valid == 2'b11, "R5 retire after completion", retire_valid, 3);
    check(retire_tag == 16'h0100, "R5 retire tags", retire_tag, 16'h0100);
    step(1'b0, 8'd0, 1'b0, 5'd0, 1'b0, 1'b0);

    // R7 younger fault then older fault: older wins
    cmpl(5'd3, 1'b1);
    cmpl(5'd2, 1'b1);
    step(1'b0, 8'd0, 1'b0, 5'd0, 1'b0, 1'b0);
    idle();
    check(flush == 1'b1, "R6 flush after fault", flush, 1);
    check(flush_tag == 8'd2, "R7 oldest fault tag", flush_tag, 2);
    step(1'b0, 8'd0, 1'b0, 5'd0, 1'b0, 1'b0);

    // R10 stale completions: wrap bit flipped and beyond tail
    for (int i = 0; i < 3; i++) alloc_one();
    cmpl(5'd18, 1'b0);
    cmpl(5'd7, 1'b0);
    idle();
    check(retire_valid == 2'b00, "R10 stale ignored", retire_valid, 0);

    // R8/R9 interrupt with pending work
    cmpl(5'd2, 1'b0);
    step(1'b1, 8'h55, 1'b1, 5'd3, 1'b0, 1'b1);
    idle();
    check(flush == 1'b1 && flush_cause == 1'b1, "R8 irq flush", {flush, flush_cause}, 3);
    check(alloc_ready == 1'b0, "R9 alloc blocked", alloc_ready, 0);
    step(1'b0, 8'd0, 1'b0, 5'd0, 1'b0, 1'b0);
    idle();
    check(flush == 1'b0, "R9 single pulse", flush, 0);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      bit         av, cv, cf, ir;
      logic [4:0] ci;
      int         sz;
      av = ($urandom % 100) < 60;
      cv = ($urandom % 100) < 70;
      cf = ($urandom % 8) == 0;
      ir = ($urandom % 60) == 0;
      sz = q_tag.size();
      if (sz > 0 && ($urandom % 5) != 0) ci = 5'((m_head + int'($urandom % sz)) & 31);
      else ci = 5'($urandom % 32);
      step(av, next_tag, cv, ci, cf, ir);
      if (av) next_tag = next_tag + 8'd1;
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule